// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles the outcome of a branch for one stage of a 32-bit integer pipeline. Each cycle that `in_valid` is high it looks at the instruction word together with the current program counter, the condition register, the count register and a register that may hold a branch target. One cycle later it presents whether the branch is taken, the program counter to fetch next, and the new value of the count register together with a write enable for it.

Three branch kinds are recognised. An unconditional branch carries a 24-bit word displacement. A conditional branch carries a 14-bit word displacement. A register-target conditional branch takes its destination from `target_reg`. A 5-bit option field steers the conditional kinds. It can ask for the count register to be decremented and tested for zero. It can also ask for one condition-register bit to be compared with an expected value. Either test can be switched off. An address-mode bit picks between a PC-relative target and an absolute target for both immediate kinds. Every other opcode passes through as a sequential, not-taken instruction.

Top module: `brc_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `taken`, `count_we`, `next_pc` and `count_next` are all zero.
- R2: `out_valid` is `in_valid` delayed by one clock, and the results describe the instruction sampled at that edge. While `in_valid` is low the results keep their previous values.
- R3: Opcode 18 (`instr[31:26]`) is an unconditional branch and is always taken, with `count_we` low. Its displacement is `instr[25:2]` shifted left by 2, with bit 25 sign-extended through bit 31. When `instr[1]` is 0 the target is `pc` plus the displacement. When `instr[1]` is 1 the target is the displacement itself.
- R4: Opcode 16 is a conditional branch with displacement `instr[15:2]` shifted left by 2, with bit 15 sign-extended through bit 31. When taken, its target is relative when `instr[1]` is 0 and absolute when `instr[1]` is 1.
- R5: Opcode 19 is a register-target conditional branch. When taken, its target is `target_reg` with bits 1:0 forced to zero.
- R6: For opcodes 16 and 19 the option field is `instr[25:21]`. When its bit of weight 4 is set, no decrement happens: `count_we` is low, `count_next` equals `count_reg`, and the counter test passes.
- R7: For opcodes 16 and 19 with option bit of weight 4 clear, `count_we` is high and `count_next` is `count_reg` minus 1, modulo 2^32. This holds whether or not the branch is taken.
- R8: The counter test, when enabled, passes if the decremented value is nonzero and option bit of weight 2 is clear. It also passes if the decremented value is zero and that bit is set. Otherwise it fails.
- R9: The condition test passes when option bit of weight 16 is set. Otherwise the bit index field is `instr[20:16]`, and the test compares bit (31 − index) of `cond_reg`, counted from the LSB, with option bit of weight 8. It passes when the two are equal.
- R10: A conditional branch is taken exactly when both the counter test and the condition test pass. When not taken, `next_pc` is `pc` + 4.
- R11: Any opcode other than 16, 18 and 19 gives `taken` low, `next_pc` = `pc` + 4, `count_we` low and `count_next` = `count_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs hold an instruction to resolve |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| cond_reg | input | 32 | Condition register |
| count_reg | input | 32 | Count register |
| target_reg | input | 32 | Register-held branch target |
| out_valid | output | 1 | Results below are fresh this cycle |
| taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Address to fetch next |
| count_we | output | 1 | Count register must be written |
| count_next | output | 32 | New count register value |

## Verification
The bench covers all 32 option values with count values of 0, 1, 2 and a large value. A count of 1 reaches zero after the decrement. A count of 0 wraps to all ones. A design that tests the count before the decrement, or that fails to wrap, takes the wrong branch decision or writes the wrong count. The condition bit index is swept at 0, 31 and midpoints. A design that numbers the bits from the LSB picks the mirrored bit. Displacements are driven at the largest positive and most negative values and near the sign bit, in both address modes. A design that sign-extends from the wrong bit sends negative branches far forward, or adds the PC in absolute mode. Register targets carry set low bits, which a design must clear. Every opcode outside the three branch kinds is swept to confirm they pass through untouched.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int XLEN   = 32;
    localparam int OPC_W  = 6;
    localparam int OPT_W  = 5;
    localparam int IDX_W  = 5;
    localparam int LDSP_W = 24;
    localparam int SDSP_W = 14;
    localparam int ALIGN  = 2;

    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int OPT_LSB  = OPC_LSB - OPT_W;
    localparam int IDX_LSB  = OPT_LSB - IDX_W;
    localparam int DSP_LSB  = ALIGN;
    localparam int ABS_BIT  = 1;

    localparam int OPT_NO_CTR   = 2;
    localparam int OPT_CTR_ZERO = 1;
    localparam int OPT_NO_CR    = 4;
    localparam int OPT_CR_WANT  = 3;

    localparam logic [OPC_W-1:0] OPC_COND_IMM = 6'd16;
    localparam logic [OPC_W-1:0] OPC_UNCOND   = 6'd18;
    localparam logic [OPC_W-1:0] OPC_COND_REG = 6'd19;

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_UNCOND,
        KIND_COND_IMM,
        KIND_COND_REG
    } br_kind_e;

    typedef struct packed {
        br_kind_e         kind;
        logic             absolute;
        logic [OPT_W-1:0] opt;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  disp;
    } br_dec_t;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] next_pc;
        logic            cnt_we;
        logic [XLEN-1:0] cnt_val;
    } br_res_t;

    function automatic logic [XLEN-1:0] ext_long(input logic [LDSP_W-1:0] f);
        return {{(XLEN-LDSP_W-ALIGN){f[LDSP_W-1]}}, f, {ALIGN{1'b0}}};
    endfunction

    function automatic logic [XLEN-1:0] ext_short(input logic [SDSP_W-1:0] f);
        return {{(XLEN-SDSP_W-ALIGN){f[SDSP_W-1]}}, f, {ALIGN{1'b0}}};
    endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
    import brc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output br_dec_t         dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc          = instr[XLEN-1:OPC_LSB];
        dec.kind     = KIND_NONE;
        dec.absolute = instr[ABS_BIT];
        dec.opt      = instr[OPC_LSB-1:OPT_LSB];
        dec.idx      = instr[OPT_LSB-1:IDX_LSB];
        dec.disp     = ext_short(instr[DSP_LSB+SDSP_W-1:DSP_LSB]);
        case (opc)
            OPC_UNCOND: begin
                dec.kind = KIND_UNCOND;
                dec.disp = ext_long(instr[DSP_LSB+LDSP_W-1:DSP_LSB]);
            end
            OPC_COND_IMM: dec.kind = KIND_COND_IMM;
            OPC_COND_REG: dec.kind = KIND_COND_REG;
            default:      dec.kind = KIND_NONE;
        endcase
    end
endmodule

// File: rtl/brc_ctr_test.sv
module brc_ctr_test
    import brc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic             enable,
    input  logic [OPT_W-1:0] opt,
    input  logic [W-1:0]     cnt_in,
    output logic             pass,
    output logic             we,
    output logic [W-1:0]     cnt_out
);
    logic [W-1:0] dec_val;
    logic         at_zero;

    always_comb begin
        dec_val = cnt_in - W'(1);
        at_zero = (dec_val == '0);
        if (!enable || opt[OPT_NO_CTR]) begin
            pass    = 1'b1;
            we      = 1'b0;
            cnt_out = cnt_in;
        end else begin
            we      = 1'b1;
            cnt_out = dec_val;
            pass    = at_zero ? opt[OPT_CTR_ZERO] : !opt[OPT_CTR_ZERO];
        end
    end
endmodule

// File: rtl/brc_cr_test.sv
module brc_cr_test
    import brc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPT_W-1:0] opt,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     cr,
    output logic             pass
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(W - 1);

    logic [IDX_W-1:0] pos;
    logic             bit_val;

    always_comb begin
        pos     = TOP - idx;
        bit_val = cr[pos];
        pass    = opt[OPT_NO_CR] ? 1'b1 : (bit_val == opt[OPT_CR_WANT]);
    end
endmodule

// File: rtl/brc_target.sv
module brc_target
    import brc_pkg::*;
(
    input  br_dec_t         dec,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] reg_tgt,
    output logic [XLEN-1:0] dest,
    output logic [XLEN-1:0] seq_pc
);
    logic [XLEN-1:0] imm_dest;

    always_comb begin
        seq_pc   = pc + INSN_BYTES;
        imm_dest = dec.absolute ? dec.disp : (pc + dec.disp);
        case (dec.kind)
            KIND_COND_REG: dest = {reg_tgt[XLEN-1:ALIGN], {ALIGN{1'b0}}};
            KIND_UNCOND,
            KIND_COND_IMM: dest = imm_dest;
            default:       dest = seq_pc;
        endcase
    end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [31:0]     pc,
    input  logic [31:0]     cond_reg,
    input  logic [31:0]     count_reg,
    input  logic [31:0]     target_reg,
    output logic            out_valid,
    output logic            taken,
    output logic [31:0]     next_pc,
    output logic            count_we,
    output logic [31:0]     count_next
);
    br_dec_t         dec;
    br_res_t         res;
    br_res_t         res_q;
    logic            is_cond;
    logic            ctr_pass;
    logic            cr_pass;
    logic            ctr_we;
    logic [XLEN-1:0] ctr_val;
    logic [XLEN-1:0] dest;
    logic [XLEN-1:0] seq_pc;
    logic            valid_q;

    brc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign is_cond = (dec.kind == KIND_COND_IMM) || (dec.kind == KIND_COND_REG);

    brc_ctr_test #(.W(XLEN)) u_ctr (
        .enable  (is_cond),
        .opt     (dec.opt),
        .cnt_in  (count_reg),
        .pass    (ctr_pass),
        .we      (ctr_we),
        .cnt_out (ctr_val)
    );

    brc_cr_test #(.W(XLEN)) u_cr (
        .opt  (dec.opt),
        .idx  (dec.idx),
        .cr   (cond_reg),
        .pass (cr_pass)
    );

    brc_target u_tgt (
        .dec     (dec),
        .pc      (pc),
        .reg_tgt (target_reg),
        .dest    (dest),
        .seq_pc  (seq_pc)
    );

    always_comb begin
        res.cnt_we  = ctr_we;
        res.cnt_val = ctr_val;
        case (dec.kind)
            KIND_UNCOND:   res.taken = 1'b1;
            KIND_COND_IMM,
            KIND_COND_REG: res.taken = ctr_pass && cr_pass;
            default:       res.taken = 1'b0;
        endcase
        res.next_pc = res.taken ? dest : seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res;
            end
        end
    end

    assign out_valid  = valid_q;
    assign taken      = res_q.taken;
    assign next_pc    = res_q.next_pc;
    assign count_we   = res_q.cnt_we;
    assign count_next = res_q.cnt_val;
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk
    import brc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] pc,
    input logic [31:0] count_reg,
    input logic        out_valid,
    input logic        taken,
    input logic [31:0] next_pc,
    input logic        count_we,
    input logic [31:0] count_next
);
    logic [OPC_W-1:0] opc;
    logic             cond_kind;
    logic             plain;

    assign opc       = instr[XLEN-1:OPC_LSB];
    assign cond_kind = (opc == OPC_COND_IMM) || (opc == OPC_COND_REG);
    assign plain     = !cond_kind && (opc != OPC_UNCOND);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !taken && !count_we && next_pc == '0 && count_next == '0));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(count_next)));

    // R3
    uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opc == OPC_UNCOND) |=> (taken && !count_we));

    // R6
    no_decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_kind && instr[OPT_LSB+OPT_NO_CTR])
        |=> (!count_we && count_next == $past(count_reg)));

    // R7
    decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_kind && !instr[OPT_LSB+OPT_NO_CTR])
        |=> (count_we && count_next == $past(count_reg) - 32'd1));

    // R10
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taken || next_pc == $past(pc) + 32'd4));

    // R11
    non_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && plain) |=> (!taken && !count_we && count_next == $past(count_reg)));
endmodule

bind brc_unit brc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .pc         (pc),
    .count_reg  (count_reg),
    .out_valid  (out_valid),
    .taken      (taken),
    .next_pc    (next_pc),
    .count_we   (count_we),
    .count_next (count_next)
);

// File: tb/brc_unit_tb.sv
`timescale 1ns/1ps
module brc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, pc, cond_reg, count_reg, target_reg;
    logic        out_valid, taken, count_we;
    logic [31:0] next_pc, count_next;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    brc_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
        .cond_reg(cond_reg), .count_reg(count_reg), .target_reg(target_reg),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .count_we(count_we), .count_next(count_next)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_br(input logic [5:0] opc, input logic [4:0] opt,
                                          input logic [4:0] idx, input logic [13:0] d,
                                          input logic aa);
        return {opc, opt, idx, d, aa, 1'b0};
    endfunction

    function automatic logic [31:0] mk_unc(input logic [23:0] li, input logic aa);
        return {6'd18, li, aa, 1'b0};
    endfunction

    // Reference computed arithmetically from the requirements.
    task automatic model(input logic [31:0] ins, p, cr, cnt, tg,
                         output logic tk, output logic [31:0] npc,
                         output logic we, output logic [31:0] cn);
        logic [31:0] opc, opt, idx, aa, d, dst;
        logic cpass, rpass;
        opc = ins >> 26; opt = (ins >> 21) & 31; idx = (ins >> 16) & 31; aa = (ins >> 1) & 1;
        tk = 1'b0; we = 1'b0; cn = cnt; dst = p + 4;
        if (opc == 18) begin
            d = ((ins >> 2) & 32'h00FF_FFFF) * 4;
            if (d >= 32'h0200_0000) d = d - 32'h0400_0000;
            dst = (aa != 0) ? d : p + d;
            tk = 1'b1;
        end else if (opc == 16 || opc == 19) begin
            if ((opt & 4) != 0) cpass = 1'b1;
            else begin
                cn = cnt - 1; we = 1'b1;
                cpass = (cn != 0) ? ((opt & 2) == 0) : ((opt & 2) != 0);
            end
            if ((opt & 16) != 0) rpass = 1'b1;
            else rpass = (((cr >> (31 - idx)) & 1) == ((opt >> 3) & 1));
            tk = cpass && rpass;
            if (opc == 16) begin
                d = ((ins >> 2) & 32'h3FFF) * 4;
                if (d >= 32'h8000) d = d - 32'h1_0000;
                dst = (aa != 0) ? d : p + d;
            end else dst = tg - (tg % 4);
        end
        npc = tk ? dst : p + 4;
    endtask

    task automatic run(input string tk_tag, input string pc_tag, input string cn_tag,
                       input logic [31:0] ins, p, cr, cnt, tg);
        logic etk, ewe;
        logic [31:0] enpc, ecn;
        model(ins, p, cr, cnt, tg, etk, enpc, ewe, ecn);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; pc = p; cond_reg = cr; count_reg = cnt; target_reg = tg;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
        chk(tk_tag, {31'd0, taken}, {31'd0, etk});
        chk(pc_tag, next_pc, enpc);
        chk(cn_tag, {31'd0, count_we}, {31'd0, ewe});
        chk(cn_tag, count_next, ecn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] cnts [4];
        logic [4:0]  idxs [4];
        logic [23:0] lis  [5];
        logic [13:0] bds  [5];
        logic [31:0] hold_pc;
        logic        hold_tk;
        cnts = '{32'd0, 32'd1, 32'd2, 32'd1000};
        idxs = '{5'd0, 5'd7, 5'd16, 5'd31};
        lis  = '{24'h000000, 24'h7FFFFF, 24'h800000, 24'hFFFFFF, 24'h123456};
        bds  = '{14'h0000, 14'h1FFF, 14'h2000, 14'h3FFF, 14'h0155};
        rst = 1'b1; in_valid = 1'b0; instr = '0; pc = '0; cond_reg = '0;
        count_reg = '0; target_reg = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 taken", {31'd0, taken}, 32'd0);
        chk("R1 next_pc", next_pc, 32'd0);
        chk("R1 count_we", {31'd0, count_we}, 32'd0);
        chk("R1 count_next", count_next, 32'd0);
        rst = 1'b0;

        // R6 R7 R8 R9 R10: every option value, bit indexes, count boundaries
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 4; i++)
                for (int c = 0; c < 4; c++) begin
                    run("R8 R9 R10 taken", "R4 R10 next_pc", "R6 R7 count",
                        mk_br(6'd16, 5'(o), idxs[i], 14'h0010, 1'b0),
                        32'h0000_4000, 32'hA5C3_0F96 ^ (32'(c) << (5 * i)),
                        cnts[c], 32'h0);
                end

        // R9 single-bit condition register: only the mirrored bit may match
        for (int i = 0; i < 32; i++) begin
            run("R9 taken", "R9 next_pc", "R9 count",
                mk_br(6'd16, 5'b00100, 5'(i), 14'h0004, 1'b0),
                32'h100, 32'h1 << (31 - i), 32'd5, 32'h0);
            run("R9 taken inv", "R9 next_pc inv", "R9 count inv",
                mk_br(6'd16, 5'b01100, 5'(i), 14'h0004, 1'b0),
                32'h100, 32'h1 << i, 32'd5, 32'h0);
        end

        // R3 unconditional displacement boundaries, both address modes
        for (int k = 0; k < 5; k++)
            for (int a = 0; a < 2; a++)
                run("R3 taken", "R3 next_pc", "R3 count",
                    mk_unc(lis[k], a[0]), 32'h0800_0000, 32'h0, 32'd9, 32'h0);

        // R4 conditional displacement boundaries, always-taken option
        for (int k = 0; k < 5; k++)
            for (int a = 0; a < 2; a++)
                run("R4 taken", "R4 next_pc", "R4 count",
                    mk_br(6'd16, 5'b10100, 5'd0, bds[k], a[0]),
                    32'h0001_0000, 32'h0, 32'd3, 32'h0);

        // R5 register targets with low bits set
        for (int o = 0; o < 32; o++)
            run("R5 taken", "R5 next_pc", "R5 R7 count",
                mk_br(6'd19, 5'(o), 5'd3, 14'h3FFF, 1'b1),
                32'h0000_2000, 32'h1000_0000, 32'(o % 3), 32'hDEAD_BEE0 | 32'(o % 4));

        // R11 every non-branch opcode
        for (int op = 0; op < 64; op++)
            if (op != 16 && op != 18 && op != 19)
                run("R11 taken", "R11 next_pc", "R11 count",
                    {6'(op), 26'h3FF_FFFF}, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'd1, 32'h40);

        // R2 hold: results unchanged while in_valid is low
        run("R2 taken", "R2 next_pc", "R2 count",
            mk_unc(24'h000010, 1'b0), 32'h0000_0100, 32'h0, 32'd7, 32'h0);
        hold_pc = next_pc; hold_tk = taken;
        instr = mk_br(6'd16, 5'b00000, 5'd0, 14'h0001, 1'b0); pc = 32'h5555_0000;
        count_reg = 32'd1;
        repeat (2) @(negedge clk);
        chk("R2 hold out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2 hold next_pc", next_pc, hold_pc);
        chk("R2 hold taken", {31'd0, taken}, {31'd0, hold_tk});
        chk("R2 hold count_we", {31'd0, count_we}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule